// File: doc/BRIEF.md
# Frame DMA Channel Address Counter

This block follows one display DMA channel through a frame: the full frame when the panel is driven in single-scan mode, or the upper half when it is driven in dual-scan mode. It holds two pointers. One is the byte address of the next 32-bit word to fetch. The other is the number of words that are still to be fetched before the frame ends. The bus master reports each finished word with a one-cycle strobe. The counter then moves the address on by one word and lowers the remaining count.

The frame length is computed from the display geometry. The line width and line count are both given as the pixel dimension minus one, and the depth is given as a bits-per-pixel code. A pixel offset is added only when 2D addressing is enabled. Each line's bit total is rounded up to whole 32-bit words and then multiplied by the line count. Both the computed length and the host base address are taken only on the new-frame strobe. Configuration that changes during a frame therefore takes effect at the next frame. A request-pending flag tells the bus master that words remain to be fetched. A one-cycle end-of-frame pulse marks the last word.

Top module: `frame_dma_addr_ctr`

## Requirements
- R1: After reset, the remaining count is 0, the address is 0, and both the pending flag and the end-of-frame pulse are low.
- R2: On a new-frame strobe, the address loads the host base address. The new value is visible in the cycle after the strobe edge.
- R3: On a new-frame strobe, the remaining count loads ceil(((line_width+1)*bpp + offset)/32) * (line_count+1).
- R4: The depth code maps 0..6 to 1, 2, 4, 8, 16, 24 and 32 bits per pixel. Code 7 gives a frame length of 0.
- R5: The pixel offset enters the length only when the 2D enable input is 1. Otherwise it is treated as 0.
- R6: A word-done strobe accepted while the remaining count is non-zero lowers the count by 1 and raises the address by 4.
- R7: A word-done strobe while the remaining count is 0 changes neither the count nor the address.
- R8: The end-of-frame output is high for exactly one cycle: the cycle in which the count has just gone from 1 to 0.
- R9: Changes to the geometry, depth, offset, enable or base inputs made between new-frame strobes do not change the count or the address.
- R10: When a new-frame strobe and a word-done strobe arrive in the same cycle, the reload wins and the word-done strobe is dropped.
- R11: The pending flag is high exactly when the remaining count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | New-frame strobe |
| word_done_i | input | 1 | One word completed by the bus master |
| base_addr_i | input | 32 | Host base address of the frame or panel |
| line_width_m1_i | input | 11 | Pixels per line minus one |
| line_count_m1_i | input | 11 | Lines per frame or panel minus one |
| bpp_code_i | input | 3 | Bits-per-pixel code (see R4) |
| pix_offset_i | input | 5 | 2D pixel offset in bits |
| en_2d_i | input | 1 | 2D addressing enable |
| fetch_addr_o | output | 32 | Byte address of the next word |
| words_left_o | output | 26 | Words still to fetch in this frame |
| req_pending_o | output | 1 | Words remain to be fetched |
| frame_end_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong latched length shows on the count output in the first cycle after the new-frame strobe. An error in the rounding or depth decode is therefore caught before any word is fetched. A counter that is off by one only shows when the frame drains. The end-of-frame pulse then comes one strobe too early or too late, and the final address misses base plus four times the length. For this reason every vector is drained to zero. Drops or double counts in the address path show on the next accepted word as an address step other than 4.

// File: rtl/fdac_pkg.sv
package fdac_pkg;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_BITS  = 32;

   typedef enum logic [2:0] {
      DEPTH_1  = 3'd0,
      DEPTH_2  = 3'd1,
      DEPTH_4  = 3'd2,
      DEPTH_8  = 3'd3,
      DEPTH_16 = 3'd4,
      DEPTH_24 = 3'd5,
      DEPTH_32 = 3'd6,
      DEPTH_XX = 3'd7
   } depth_code_e;

endpackage

// File: rtl/fdac_size_calc.sv
module fdac_size_calc
   import fdac_pkg::*;
#(
   parameter int LINE_W = 11,
   parameter int ROWS_W = 11,
   parameter int POFF_W = 5,
   parameter bit HAS_2D = 1'b1,
   localparam int PIX_W  = LINE_W + 1,
   localparam int BITS_W = PIX_W + 7,
   localparam int XS_W   = BITS_W - 5,
   localparam int FRM_W  = XS_W + ROWS_W + 1
) (
   input  logic [LINE_W-1:0] line_width_m1,
   input  logic [ROWS_W-1:0] line_count_m1,
   input  logic [2:0]        depth_code,
   input  logic [POFF_W-1:0] pix_offset,
   input  logic              en_2d,
   output logic [FRM_W-1:0]  frame_words
);

   if (POFF_W > PIX_W + 5) begin : g_bad_poff
      $error("fdac_size_calc: POFF_W too wide for BITS_W");
   end

   logic [BITS_W-1:0] pix;
   logic [BITS_W-1:0] line_bits;
   logic [BITS_W-1:0] off_eff;
   logic [BITS_W-1:0] total_bits;
   logic [XS_W-1:0]   words_per_line;
   logic [ROWS_W:0]   rows;
   logic              depth_ok;

   assign pix = BITS_W'(line_width_m1) + BITS_W'(1);

   always_comb begin
      depth_ok  = 1'b1;
      line_bits = '0;
      case (depth_code_e'(depth_code))
         DEPTH_1:  line_bits = pix;
         DEPTH_2:  line_bits = pix << 1;
         DEPTH_4:  line_bits = pix << 2;
         DEPTH_8:  line_bits = pix << 3;
         DEPTH_16: line_bits = pix << 4;
         DEPTH_24: line_bits = (pix << 4) + (pix << 3);
         DEPTH_32: line_bits = pix << 5;
         default: begin
            line_bits = '0;
            depth_ok  = 1'b0;
         end
      endcase
   end

   if (HAS_2D) begin : g_offset_on
      assign off_eff = en_2d ? BITS_W'(pix_offset) : '0;
   end else begin : g_offset_off
      logic unused_offset;
      assign unused_offset = ^{pix_offset, en_2d};
      assign off_eff = '0;
   end

   assign total_bits     = line_bits + off_eff;
   assign words_per_line = XS_W'((total_bits + BITS_W'(WORD_BITS - 1)) >> 5);
   assign rows           = {1'b0, line_count_m1} + 1'b1;
   assign frame_words    = depth_ok ? (FRM_W'(words_per_line) * FRM_W'(rows)) : '0;

endmodule

// File: rtl/fdac_word_ctr.sv
module fdac_word_ctr #(
   parameter int CNT_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic             word_done,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             accept,
   output logic             frame_end
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("fdac_word_ctr: CNT_W must be at least 2");
   end

   logic last_word;

   assign accept    = word_done && !reload && (count != '0);
   assign last_word = (count == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         frame_end <= 1'b0;
      end else begin
         frame_end <= accept && last_word;
         if (reload) begin
            count <= load_val;
         end else if (accept) begin
            count <= count - CNT_W'(1);
         end
      end
   end

   AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !reload) |=> count == '0); // R7

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !reload && count != '0) |=> count == $past(count) - CNT_W'(1)); // R6

endmodule

// File: rtl/fdac_addr_ptr.sv
module fdac_addr_ptr
   import fdac_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("fdac_addr_ptr: ADDR_W must be at least 3");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (reload) begin
         addr <= base_addr;
      end else if (advance) begin
         addr <= addr + STEP;
      end
   end

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !advance) |=> $stable(addr)); // R7

endmodule

// File: rtl/frame_dma_addr_ctr.sv
module frame_dma_addr_ctr
   import fdac_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 11,
   parameter int ROWS_W = 11,
   parameter int POFF_W = 5,
   parameter bit HAS_2D = 1'b1,
   localparam int CNT_W = (LINE_W + 8 - 5) + ROWS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start_i,
   input  logic              word_done_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [LINE_W-1:0] line_width_m1_i,
   input  logic [ROWS_W-1:0] line_count_m1_i,
   input  logic [2:0]        bpp_code_i,
   input  logic [POFF_W-1:0] pix_offset_i,
   input  logic              en_2d_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic [CNT_W-1:0]  words_left_o,
   output logic              req_pending_o,
   output logic              frame_end_o
);

   logic [CNT_W-1:0] frame_words;
   logic             accept;

   fdac_size_calc #(
      .LINE_W(LINE_W), .ROWS_W(ROWS_W), .POFF_W(POFF_W), .HAS_2D(HAS_2D)
   ) u_size (
      .line_width_m1(line_width_m1_i),
      .line_count_m1(line_count_m1_i),
      .depth_code   (bpp_code_i),
      .pix_offset   (pix_offset_i),
      .en_2d        (en_2d_i),
      .frame_words  (frame_words)
   );

   fdac_word_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (frame_start_i),
      .word_done(word_done_i),
      .load_val (frame_words),
      .count    (words_left_o),
      .accept   (accept),
      .frame_end(frame_end_o)
   );

   fdac_addr_ptr #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (frame_start_i),
      .advance  (accept),
      .base_addr(base_addr_i),
      .addr     (fetch_addr_o)
   );

   assign req_pending_o = (words_left_o != '0);

   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_i |=> fetch_addr_o == $past(base_addr_i)); // R2

   AST_SIZE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_i |=> words_left_o == $past(frame_words)); // R3

   AST_EOF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end_o |-> (words_left_o == '0 && !req_pending_o)); // R8

   AST_ADDR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done_i && !frame_start_i && req_pending_o) |=>
         fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(WORD_BYTES)); // R6

endmodule

// File: tb/frame_dma_addr_ctr_tb_top.sv
module frame_dma_addr_ctr_tb_top;

   localparam int ADDR_W = 32;
   localparam int CNT_W  = 26;

   typedef struct packed {
      logic [10:0] lw;
      logic [10:0] lc;
      logic [2:0]  bpp;
      logic [4:0]  off;
      logic        en;
      logic [31:0] exp_words;
   } vec_t;

   // R3/R4/R5 expected lengths, worked by hand from the requirements
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{11'd0,    11'd0, 3'd0, 5'd0,  1'b0, 32'd1},
      '{11'd31,   11'd1, 3'd1, 5'd0,  1'b0, 32'd4},
      '{11'd9,    11'd2, 3'd5, 5'd0,  1'b0, 32'd24},
      '{11'd3,    11'd3, 3'd6, 5'd0,  1'b0, 32'd16},
      '{11'd7,    11'd0, 3'd3, 5'd5,  1'b1, 32'd3},
      '{11'd7,    11'd0, 3'd3, 5'd5,  1'b0, 32'd2},
      '{11'd15,   11'd4, 3'd2, 5'd0,  1'b0, 32'd10},
      '{11'd4,    11'd1, 3'd4, 5'd0,  1'b0, 32'd6},
      '{11'd3,    11'd3, 3'd7, 5'd0,  1'b0, 32'd0},
      '{11'd2047, 11'd0, 3'd6, 5'd31, 1'b1, 32'd2049}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_start_i = 1'b0;
   logic              word_done_i = 1'b0;
   logic [ADDR_W-1:0] base_addr_i = '0;
   logic [10:0]       line_width_m1_i = '0;
   logic [10:0]       line_count_m1_i = '0;
   logic [2:0]        bpp_code_i = '0;
   logic [4:0]        pix_offset_i = '0;
   logic              en_2d_i = 1'b0;
   logic [ADDR_W-1:0] fetch_addr_o;
   logic [CNT_W-1:0]  words_left_o;
   logic              req_pending_o;
   logic              frame_end_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   frame_dma_addr_ctr dut_i (
      .clk(clk), .rst_n(rst_n),
      .frame_start_i(frame_start_i), .word_done_i(word_done_i),
      .base_addr_i(base_addr_i),
      .line_width_m1_i(line_width_m1_i), .line_count_m1_i(line_count_m1_i),
      .bpp_code_i(bpp_code_i), .pix_offset_i(pix_offset_i), .en_2d_i(en_2d_i),
      .fetch_addr_o(fetch_addr_o), .words_left_o(words_left_o),
      .req_pending_o(req_pending_o), .frame_end_o(frame_end_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(input vec_t v, input logic [31:0] base);
      line_width_m1_i = v.lw;
      line_count_m1_i = v.lc;
      bpp_code_i      = v.bpp;
      pix_offset_i    = v.off;
      en_2d_i         = v.en;
      base_addr_i     = base;
   endtask

   task automatic start_frame();
      frame_start_i = 1'b1;
      tick();
      frame_start_i = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      tick(); tick();
      check("R1 count", 32'(words_left_o), 32'd0);
      check("R1 addr", fetch_addr_o, 32'd0);
      check("R1 pending", 32'(req_pending_o), 32'd0);
      check("R1 eof", 32'(frame_end_o), 32'd0);
      rst_n = 1'b1;
      tick();

      // vector table: load, check length and base, then drain
      for (int i = 0; i < NV; i++) begin
         automatic logic [31:0] base = 32'h1000_0000 + 32'(i) * 32'h100;
         automatic int eof_seen = 0;
         automatic int eof_at = -1;
         set_cfg(VECS[i], base);
         start_frame();
         check("R3/R4/R5 length", 32'(words_left_o), VECS[i].exp_words);
         check("R2 base load", fetch_addr_o, base);
         check("R11 pending", 32'(req_pending_o), 32'(VECS[i].exp_words != 0));
         for (int k = 0; k < int'(VECS[i].exp_words); k++) begin
            word_done_i = 1'b1;
            tick();
            if (frame_end_o) begin eof_seen++; eof_at = k; end
         end
         word_done_i = 1'b0;
         tick();
         if (frame_end_o) eof_seen++;
         check("R6 final addr", fetch_addr_o, base + 32'd4 * VECS[i].exp_words);
         check("R6 drained", 32'(words_left_o), 32'd0);
         check("R11 idle pending", 32'(req_pending_o), 32'd0);
         if (VECS[i].exp_words != 0) begin
            check("R8 eof count", 32'(eof_seen), 32'd1);
            check("R8 eof position", 32'(eof_at), VECS[i].exp_words - 32'd1);
         end else begin
            check("R8 no eof on empty", 32'(eof_seen), 32'd0);
         end
      end

      // R7 strobes at zero are ignored
      begin
         automatic logic [31:0] a0 = fetch_addr_o;
         word_done_i = 1'b1;
         tick(); tick(); tick();
         word_done_i = 1'b0;
         check("R7 count stays 0", 32'(words_left_o), 32'd0);
         check("R7 addr stable", fetch_addr_o, a0);
         check("R7 no eof", 32'(frame_end_o), 32'd0);
      end

      // R6 single step and R9 mid-frame config change
      set_cfg(VECS[6], 32'h2000_0000);   // 10 words
      start_frame();
      word_done_i = 1'b1;
      tick();
      word_done_i = 1'b0;
      check("R6 step count", 32'(words_left_o), 32'd9);
      check("R6 step addr", fetch_addr_o, 32'h2000_0004);
      word_done_i = 1'b1;
      tick();
      word_done_i = 1'b0;
      set_cfg(VECS[9], 32'h3000_0000);
      tick();
      check("R9 count kept", 32'(words_left_o), 32'd8);
      check("R9 addr kept", fetch_addr_o, 32'h2000_0008);
      word_done_i = 1'b1;
      tick();
      word_done_i = 1'b0;
      check("R9 count after step", 32'(words_left_o), 32'd7);
      check("R9 addr after step", fetch_addr_o, 32'h2000_000C);

      // R10 reload beats simultaneous word-done
      frame_start_i = 1'b1;
      word_done_i   = 1'b1;
      tick();
      frame_start_i = 1'b0;
      word_done_i   = 1'b0;
      check("R10 count reloaded", 32'(words_left_o), 32'd2049);
      check("R10 addr reloaded", fetch_addr_o, 32'h3000_0000);
      check("R8 no eof on reload", 32'(frame_end_o), 32'd0);

      // R5 offset ignored when 2D disabled, even with large offset
      set_cfg(VECS[5], 32'h4000_0000);
      pix_offset_i = 5'd31;
      start_frame();
      check("R5 offset ignored", 32'(words_left_o), 32'd2);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule